// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Line Ownership

This block manages a set of general-purpose I/O lines through a 32-bit register port that completes each access in one cycle. Every line has an output value, an output enable, a synchronized input and a level-sensitive interrupt. Each interrupt has its own active-level select, a sticky pending bit and an enable. Two register banks share one layout. One bank is open to any bus master. The other, the guarded bank, answers only while the `guard_ok_i` permission input is high.

A per-line ownership vector sits in a guarded control region and decides which bank controls each line. Through the bank that does not own a line, that line cannot be driven, configured or made to interrupt. Each bank raises its own interrupt output. Interrupts are level-only. Software that needs edge behaviour flips a line's active level after each event. A per-line enable in the control region gates all pad drive.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset the following hold. Drive, direction, interrupt-enable and pending bits are zero in both banks. Active-level bits are all ones. The ownership vector is zero, so every line belongs to the guarded bank. The line-enable vector is zero. `pin_oe_o` is zero and both interrupt outputs are low.
- R2: The address map is as follows. Address bits [6:5] pick the region: 0 for the open bank, 1 for the guarded bank, 2 for the control region. Bits [4:2] pick the word and bits [1:0] are ignored. The bank words are, in order: 0 input level, 1 input mirror, 2 drive, 3 direction, 4 active level, 5 interrupt enable, 6 pending. Bank word 7, control words 2 to 7 and region 3 read as zero. Control word 0 is ownership and word 1 is line enable.
- R3: An ownership bit of 1 gives line n to the open bank and 0 gives it to the guarded bank. Writes to drive, direction, active level and interrupt enable through a bank change only the bits of lines that bank owns. Reads of those words and of pending return zero for lines the bank does not own.
- R4: While `guard_ok_i` is low, writes to the guarded bank and to the control region are ignored and reads from them return zero. The open bank works regardless of `guard_ok_i`.
- R5: `pin_out_o[n]` follows the drive bit of the bank that owns line n. `pin_oe_o[n]` is that bank's direction bit ANDed with line-enable bit n.
- R6: Inputs pass through two flip-flops. The input-level and mirror words of either bank both return this synchronized value for all lines. A pin change becomes readable after the second rising clock edge.
- R7: On any clock cycle where a line's synchronized input equals its active-level bit, the owning bank sets that line's pending bit. An active-level bit of 1 triggers on high and 0 triggers on low.
- R8: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged, so an all-ones write clears every owned bit. A pending bit stays set while its level is still active, even if a clear is written.
- R9: A bank's interrupt output is the OR, over the lines it owns, of pending AND interrupt enable. An enable bit of 0 suppresses that line.
- R10: When a line leaves a bank, that bank's pending bit for the line is cleared on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| guard_ok_i | input | 1 | Permission to reach the guarded bank and control region |
| bus_addr_i | input | 7 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data, one bit per line |
| bus_rdata_o | output | 32 | Read data for the current address, same cycle |
| pin_in_i | input | 32 | Asynchronous pad inputs |
| pin_out_o | output | 32 | Pad output values |
| pin_oe_o | output | 32 | Pad output enables |
| irq_open_o | output | 1 | Interrupt request of the open bank |
| irq_guard_o | output | 1 | Interrupt request of the guarded bank |

## Verification
The assertions assume that `guard_ok_i`, the address and the write strobe are stable around each rising edge. They also assume that a pin change reaches the pending logic only through the synchronizer. The pending-bit properties therefore treat the synchronized level seen in the previous cycle as the only cause of a new pending bit. The stimulus changes bus signals and pins only on falling edges and holds each write for exactly one cycle. It waits several cycles after every pin change before it reads pending state, so no check depends on a partly settled synchronizer.

// File: rtl/gpio_dual_bank_pkg.sv
package gpio_dual_bank_pkg;

    // Word select inside a bank region
    localparam int unsigned SLOT_W   = 3;
    localparam int unsigned SLOT_LSB = 2;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_LEVEL  = 3'd0,
        SLOT_MIRROR = 3'd1,
        SLOT_DRIVE  = 3'd2,
        SLOT_DIR    = 3'd3,
        SLOT_POL    = 3'd4,
        SLOT_IEN    = 3'd5,
        SLOT_PEND   = 3'd6,
        SLOT_SPARE  = 3'd7
    } slot_e;

    typedef enum logic [1:0] {
        REGION_OPEN  = 2'd0,
        REGION_GUARD = 2'd1,
        REGION_CTRL  = 2'd2,
        REGION_NONE  = 2'd3
    } region_e;

    // Words of the control region
    localparam logic [SLOT_W-1:0] CTRL_OWNER  = 3'd0;
    localparam logic [SLOT_W-1:0] CTRL_ENABLE = 3'd1;

endpackage

// File: rtl/gpio_dual_bank_sync.sv
module gpio_dual_bank_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stage_d[g] = async_i;
        end else begin : g_next
            assign stage_d[g] = stage_q[g-1];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                stage_q[g] <= '0;
            end else begin
                stage_q[g] <= stage_d[g];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_dual_bank_bank.sv
module gpio_dual_bank_bank
    import gpio_dual_bank_pkg::*;
#(
    parameter int unsigned NLINES = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NLINES-1:0] owned_i,
    input  logic              wr_i,
    input  slot_e             slot_i,
    input  logic [NLINES-1:0] wdata_i,
    input  logic [NLINES-1:0] level_i,
    output logic [NLINES-1:0] rdata_o,
    output logic [NLINES-1:0] drive_o,
    output logic [NLINES-1:0] dir_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [NLINES-1:0] drive;
        logic [NLINES-1:0] dir;
        logic [NLINES-1:0] pol;
        logic [NLINES-1:0] ien;
        logic [NLINES-1:0] pend;
    } bank_t;

    bank_t             st_d;
    bank_t             st_q;
    logic [NLINES-1:0] hit;
    logic [NLINES-1:0] clr;

    // Replace only the bits this bank owns
    function automatic logic [NLINES-1:0] merge_owned(
        input logic [NLINES-1:0] old_v,
        input logic [NLINES-1:0] new_v,
        input logic [NLINES-1:0] own_v
    );
        return (old_v & ~own_v) | (new_v & own_v);
    endfunction

    always_comb begin
        st_d = st_q;
        hit  = owned_i & ~(level_i ^ st_q.pol);
        clr  = '0;
        if (wr_i) begin
            unique case (slot_i)
                SLOT_DRIVE: st_d.drive = merge_owned(st_q.drive, wdata_i, owned_i);
                SLOT_DIR:   st_d.dir   = merge_owned(st_q.dir,   wdata_i, owned_i);
                SLOT_POL:   st_d.pol   = merge_owned(st_q.pol,   wdata_i, owned_i);
                SLOT_IEN:   st_d.ien   = merge_owned(st_q.ien,   wdata_i, owned_i);
                SLOT_PEND:  clr        = wdata_i & owned_i;
                default:    ;
            endcase
        end
        // a clear loses against a level that is still active
        st_d.pend = ((st_q.pend & ~clr) | hit) & owned_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.drive <= '0;
            st_q.dir   <= '0;
            st_q.pol   <= '1;
            st_q.ien   <= '0;
            st_q.pend  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (slot_i)
            SLOT_LEVEL, SLOT_MIRROR: rdata_o = level_i;
            SLOT_DRIVE:              rdata_o = st_q.drive & owned_i;
            SLOT_DIR:                rdata_o = st_q.dir   & owned_i;
            SLOT_POL:                rdata_o = st_q.pol   & owned_i;
            SLOT_IEN:                rdata_o = st_q.ien   & owned_i;
            SLOT_PEND:               rdata_o = st_q.pend  & owned_i;
            default:                 rdata_o = '0;
        endcase
    end

    assign drive_o = st_q.drive;
    assign dir_o   = st_q.dir;
    assign irq_o   = |(st_q.pend & st_q.ien & owned_i);

    AST_PEND_ONLY_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.pend & ~$past(owned_i)) == '0)); // R10

    AST_PEND_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.pend & ~$past(st_q.pend) & ~$past(hit)) == '0)); // R7

    AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(st_q.pend) & ~st_q.pend & ~$past(clr) & $past(owned_i)) == '0)); // R8

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (|(st_q.ien & owned_i))); // R9

endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
    import gpio_dual_bank_pkg::*;
#(
    parameter int unsigned NLINES      = 32,
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              guard_ok_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [NLINES-1:0] bus_wdata_i,
    output logic [NLINES-1:0] bus_rdata_o,
    input  logic [NLINES-1:0] pin_in_i,
    output logic [NLINES-1:0] pin_out_o,
    output logic [NLINES-1:0] pin_oe_o,
    output logic              irq_open_o,
    output logic              irq_guard_o
);

    localparam int unsigned REGION_LSB = SLOT_LSB + SLOT_W;
    localparam int unsigned REGION_W   = ADDR_W - REGION_LSB;

    typedef struct packed {
        logic [NLINES-1:0] owner;
        logic [NLINES-1:0] enable;
    } ctrl_t;

    ctrl_t               st_d;
    ctrl_t               st_q;
    region_e             region;
    slot_e               slot;
    logic [REGION_W-1:0] region_raw;
    logic [1:0]          addr_unused;
    logic                wr_open;
    logic                wr_guard;
    logic                wr_ctrl;
    logic [NLINES-1:0]   level_sync;
    logic [NLINES-1:0]   open_rdata;
    logic [NLINES-1:0]   guard_rdata;
    logic [NLINES-1:0]   open_drive;
    logic [NLINES-1:0]   guard_drive;
    logic [NLINES-1:0]   open_dir;
    logic [NLINES-1:0]   guard_dir;

    assign addr_unused = bus_addr_i[SLOT_LSB-1:0];
    assign region_raw  = bus_addr_i[ADDR_W-1:REGION_LSB];
    assign slot        = slot_e'(bus_addr_i[SLOT_LSB +: SLOT_W]);

    always_comb begin
        if (region_raw == '0) begin
            region = REGION_OPEN;
        end else if (region_raw == REGION_W'(1)) begin
            region = REGION_GUARD;
        end else if (region_raw == REGION_W'(2)) begin
            region = REGION_CTRL;
        end else begin
            region = REGION_NONE;
        end
    end

    assign wr_open  = bus_wr_i && (region == REGION_OPEN);
    assign wr_guard = bus_wr_i && guard_ok_i && (region == REGION_GUARD);
    assign wr_ctrl  = bus_wr_i && guard_ok_i && (region == REGION_CTRL);

    gpio_dual_bank_sync #(
        .WIDTH  (NLINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_in_i),
        .sync_o  (level_sync)
    );

    gpio_dual_bank_bank #(
        .NLINES (NLINES)
    ) u_open (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .owned_i (st_q.owner),
        .wr_i    (wr_open),
        .slot_i  (slot),
        .wdata_i (bus_wdata_i),
        .level_i (level_sync),
        .rdata_o (open_rdata),
        .drive_o (open_drive),
        .dir_o   (open_dir),
        .irq_o   (irq_open_o)
    );

    gpio_dual_bank_bank #(
        .NLINES (NLINES)
    ) u_guard (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .owned_i (~st_q.owner),
        .wr_i    (wr_guard),
        .slot_i  (slot),
        .wdata_i (bus_wdata_i),
        .level_i (level_sync),
        .rdata_o (guard_rdata),
        .drive_o (guard_drive),
        .dir_o   (guard_dir),
        .irq_o   (irq_guard_o)
    );

    // Control region next state
    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            if (slot == CTRL_OWNER) begin
                st_d.owner = bus_wdata_i;
            end else if (slot == CTRL_ENABLE) begin
                st_d.enable = bus_wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.owner  <= '0;
            st_q.enable <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read path, same cycle
    always_comb begin
        bus_rdata_o = '0;
        unique case (region)
            REGION_OPEN:  bus_rdata_o = open_rdata;
            REGION_GUARD: bus_rdata_o = guard_ok_i ? guard_rdata : '0;
            REGION_CTRL: begin
                if (guard_ok_i) begin
                    if (slot == CTRL_OWNER) begin
                        bus_rdata_o = st_q.owner;
                    end else if (slot == CTRL_ENABLE) begin
                        bus_rdata_o = st_q.enable;
                    end
                end
            end
            default: bus_rdata_o = '0;
        endcase
    end

    // Per-line pad steering toward the owning bank
    for (genvar l = 0; l < NLINES; l++) begin : g_line
        assign pin_out_o[l] = st_q.owner[l] ? open_drive[l] : guard_drive[l];
        assign pin_oe_o[l]  = st_q.enable[l] & (st_q.owner[l] ? open_dir[l] : guard_dir[l]);
    end

    AST_GUARD_WRITE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && !guard_ok_i && (region == REGION_CTRL))
        |=> ($stable(st_q.owner) && $stable(st_q.enable))); // R4

    AST_GUARD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!guard_ok_i && ((region == REGION_GUARD) || (region == REGION_CTRL)))
        |-> (bus_rdata_o == '0)); // R4

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (region == REGION_NONE) |-> (bus_rdata_o == '0)); // R2

    AST_OE_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |-> ((pin_oe_o & ~st_q.enable) == '0)); // R5

endmodule

// File: tb/gpio_dual_bank_bench.sv
module gpio_dual_bank_bench;

    localparam logic [6:0] OPEN   = 7'h00;
    localparam logic [6:0] GUARD  = 7'h20;
    localparam logic [6:0] W_LVL  = 7'h00;
    localparam logic [6:0] W_MIR  = 7'h04;
    localparam logic [6:0] W_DRV  = 7'h08;
    localparam logic [6:0] W_DIR  = 7'h0C;
    localparam logic [6:0] W_POL  = 7'h10;
    localparam logic [6:0] W_IEN  = 7'h14;
    localparam logic [6:0] W_PEND = 7'h18;
    localparam logic [6:0] OWNER  = 7'h40;
    localparam logic [6:0] ENABLE = 7'h44;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        guard_ok;
    logic [6:0]  addr;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq_open;
    logic        irq_guard;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    gpio_dual_bank u_gpio_dual_bank (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .guard_ok_i  (guard_ok),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .pin_in_i    (pin_in),
        .pin_out_o   (pin_out),
        .pin_oe_o    (pin_oe),
        .irq_open_o  (irq_open),
        .irq_guard_o (irq_guard)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 oe", pin_oe, 32'h0);
        chk("R1 irq", {30'h0, irq_open, irq_guard}, 32'h0);
        rd_reg(OWNER, d);          chk("R1 owner", d, 32'h0);
        rd_reg(ENABLE, d);         chk("R1 enable", d, 32'h0);
        rd_reg(GUARD | W_DRV, d);  chk("R1 drive", d, 32'h0);
        rd_reg(GUARD | W_POL, d);  chk("R1 polarity", d, 32'hFFFF_FFFF);
        rd_reg(OPEN | W_POL, d);   chk("R3 unowned polarity", d, 32'h0);
        rd_reg(GUARD | W_PEND, d); chk("R1 pending", d, 32'h0);
    endtask

    task automatic t_owner_split();
        logic [31:0] d;
        wr_reg(OWNER, 32'h0000_FFFF);
        wr_reg(OPEN | W_DRV, 32'hFFFF_FFFF);
        rd_reg(OPEN | W_DRV, d);   chk("R3 open drive", d, 32'h0000_FFFF);
        wr_reg(GUARD | W_DRV, 32'hA5A5_A5A5);
        rd_reg(GUARD | W_DRV, d);  chk("R3 guard drive", d, 32'hA5A5_0000);
        chk("R5 pin_out", pin_out, 32'hA5A5_FFFF);
        wr_reg(OPEN | W_DIR, 32'h0000_00FF);
        wr_reg(GUARD | W_DIR, 32'hFF00_0000);
        rd_reg(OPEN | W_DIR, d);   chk("R3 open dir", d, 32'h0000_00FF);
        chk("R5 oe gated by enable", pin_oe, 32'h0);
        wr_reg(ENABLE, 32'hFFFF_FFFF);
        settle(1);                 chk("R5 oe full", pin_oe, 32'hFF00_00FF);
        wr_reg(ENABLE, 32'h0F00_00F0);
        settle(1);                 chk("R5 oe partial", pin_oe, 32'h0F00_00F0);
        rd_reg(7'h0B, d);          chk("R2 low addr bits", d, 32'h0000_FFFF);
        rd_reg(7'h60, d);          chk("R2 unmapped region", d, 32'h0);
        rd_reg(OPEN | 7'h1C, d);   chk("R2 spare word", d, 32'h0);
        rd_reg(7'h48, d);          chk("R2 spare control word", d, 32'h0);
    endtask

    task automatic t_guard();
        logic [31:0] d;
        guard_ok = 1'b0;
        wr_reg(OWNER, 32'hFFFF_FFFF);
        wr_reg(GUARD | W_DRV, 32'h0);
        wr_reg(ENABLE, 32'h0);
        rd_reg(OWNER, d);          chk("R4 owner read blocked", d, 32'h0);
        rd_reg(GUARD | W_DRV, d);  chk("R4 guard read blocked", d, 32'h0);
        rd_reg(OPEN | W_DRV, d);   chk("R4 open bank usable", d, 32'h0000_FFFF);
        chk("R4 oe kept", pin_oe, 32'h0F00_00F0);
        chk("R4 pin_out kept", pin_out, 32'hA5A5_FFFF);
        guard_ok = 1'b1;
        rd_reg(OWNER, d);          chk("R4 owner kept", d, 32'h0000_FFFF);
        rd_reg(GUARD | W_DRV, d);  chk("R4 guard drive kept", d, 32'hA5A5_0000);
    endtask

    task automatic t_sync();
        logic [31:0] d;
        @(negedge clk);
        pin_in = 32'h1234_5678;
        addr   = OPEN | W_LVL;
        #1;                        chk("R6 before edges", rdata, 32'h0);
        @(negedge clk); #1;        chk("R6 after one edge", rdata, 32'h0);
        @(negedge clk); #1;        chk("R6 after two edges", rdata, 32'h1234_5678);
        rd_reg(GUARD | W_MIR, d);  chk("R6 guard mirror", d, 32'h1234_5678);
        rd_reg(OPEN | W_MIR, d);   chk("R6 open mirror", d, 32'h1234_5678);
        pin_in = 32'h0;
        settle(4);
        wr_reg(OPEN | W_PEND, 32'hFFFF_FFFF);
        wr_reg(GUARD | W_PEND, 32'hFFFF_FFFF);
        rd_reg(GUARD | W_PEND, d); chk("R8 clear all guard", d, 32'h0);
        rd_reg(OPEN | W_PEND, d);  chk("R8 clear all open", d, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr_reg(OPEN | W_IEN, 32'h1);
        pin_in = 32'h1;
        settle(4);
        rd_reg(OPEN | W_PEND, d);  chk("R7 high active", d, 32'h1);
        chk("R9 open irq", {30'h0, irq_open, irq_guard}, 32'h2);
        pin_in = 32'h0;
        settle(4);
        rd_reg(OPEN | W_PEND, d);  chk("R8 sticky", d, 32'h1);
        wr_reg(OPEN | W_PEND, 32'h0);
        rd_reg(OPEN | W_PEND, d);  chk("R8 write zero", d, 32'h1);
        wr_reg(OPEN | W_PEND, 32'h1);
        rd_reg(OPEN | W_PEND, d);  chk("R8 write one", d, 32'h0);
        chk("R9 irq drops", {31'h0, irq_open}, 32'h0);
        pin_in = 32'h2;
        settle(4);
        rd_reg(OPEN | W_PEND, d);  chk("R7 unmasked line", d, 32'h2);
        chk("R9 masked line", {31'h0, irq_open}, 32'h0);
        pin_in = 32'h0;
        settle(4);
        wr_reg(OPEN | W_PEND, 32'hFFFF_FFFF);
        rd_reg(OPEN | W_PEND, d);  chk("R8 all ones", d, 32'h0);
        wr_reg(GUARD | W_POL, 32'hFFEF_FFFF);
        rd_reg(GUARD | W_POL, d);  chk("R3 guard polarity", d, 32'hFFEF_0000);
        wr_reg(GUARD | W_IEN, 32'h0010_0000);
        settle(4);
        rd_reg(GUARD | W_PEND, d); chk("R7 low active", d, 32'h0010_0000);
        chk("R9 guard irq", {30'h0, irq_open, irq_guard}, 32'h1);
        wr_reg(GUARD | W_PEND, 32'h0010_0000);
        rd_reg(GUARD | W_PEND, d); chk("R8 reassert", d, 32'h0010_0000);
        pin_in = 32'h0010_0000;
        settle(4);
        wr_reg(GUARD | W_PEND, 32'hFFFF_FFFF);
        rd_reg(GUARD | W_PEND, d); chk("R8 cleared when idle", d, 32'h0);
        chk("R9 guard irq drops", {31'h0, irq_guard}, 32'h0);
        wr_reg(GUARD | W_POL, 32'hFFFF_FFFF);
        settle(3);
        rd_reg(GUARD | W_PEND, d); chk("R7 flipped level", d, 32'h0010_0000);
        pin_in = 32'h0;
        settle(4);
        wr_reg(GUARD | W_PEND, 32'hFFFF_FFFF);
        rd_reg(GUARD | W_PEND, d); chk("R8 final clear", d, 32'h0);
    endtask

    task automatic t_move();
        logic [31:0] d;
        pin_in = 32'h1;
        settle(4);
        chk("R9 before move", {31'h0, irq_open}, 32'h1);
        wr_reg(OWNER, 32'h0000_FFFE);
        settle(3);
        rd_reg(OPEN | W_PEND, d);  chk("R10 old bank pending", d, 32'h0);
        chk("R10 old bank irq", {31'h0, irq_open}, 32'h0);
        rd_reg(GUARD | W_PEND, d); chk("R7 new bank pending", d, 32'h1);
        chk("R9 new bank masked", {31'h0, irq_guard}, 32'h0);
        chk("R5 pin_out after move", pin_out, 32'hA5A5_FFFE);
        pin_in = 32'h0;
    endtask

    initial begin
        rst_n    = 1'b0;
        guard_ok = 1'b1;
        addr     = '0;
        wr       = 1'b0;
        wdata    = '0;
        pin_in   = '0;
        settle(3);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_owner_split();
        t_guard();
        t_sync();
        t_irq();
        t_move();
        settle(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule